// File: doc/BRIEF.md
# Reference Frequency Window Detector

This block judges whether a locally generated bit-rate clock runs within a narrow tolerance of its nominal frequency. The local clock passes through a two-stage divider. The first stage follows the line-rate selection and the second stage follows the reference-frequency selection, so the divided tick rate nominally equals the reference frequency. A timer in the reference domain marks measurement intervals of a fixed number of reference cycles. At the end of each interval the number of divided ticks is compared with an inclusive window around that cycle count.

Inside the window the block enables the phase detector and raises its lock flag. Outside the window it turns the phase detector off and drives a coarse steering command that pushes the oscillator back toward nominal. A watchdog in the local domain detects a reference that has stopped. While the reference is missing, lock is forced low and no steering is issued. The lock flag only reports frequency agreement with the reference. It says nothing about phase alignment to the incoming data.

Only single-bit toggles cross between the two clock domains, and each passes through a synchronizer. No multi-bit count crosses. The mode pins are quasi-static and sampled in the local domain.

Top module: `freq_window_det`

## Requirements
- R1: After reset, lock, pd_en, steer_up and steer_dn are all 0.
- R2: The first-stage divide ratio is RATE_LO_DIV (default 16) when rate_sel=0 and RATE_HI_DIV (default 4) when rate_sel=1. The second-stage ratio is REF_HI_DIV (default 64) when ref_sel=0 and REF_LO_DIV (default 128) when ref_sel=1. The tick count measured per interval is the local-clock cycles divided by the product of the two ratios.
- R3: Let M = floor(IVL_REF_CYCLES*TOL_PPM/1e6), with TOL_PPM defaulting to 1000. A tick count within [IVL_REF_CYCLES-M, IVL_REF_CYCLES+M] inclusive sets pd_en=1 and lock=1, with no steering.
- R4: A count above the upper bound sets steer_dn=1, steer_up=0, pd_en=0 and lock=0.
- R5: A count below the lower bound sets steer_up=1, steer_dn=0, pd_en=0 and lock=0.
- R6: pd_en, steer_up and steer_dn change only at the end of a measurement interval or when the reference is declared lost. Between those events they hold.
- R7: If no reference edge reaches the local domain within WDOG_CYCLES local cycles, the reference is lost. From the next cycle on, lock, pd_en, steer_up and steer_dn are all 0.
- R8: The first interval after reset, and the first interval after a lost reference returns, are discarded without judgment. Lock therefore stays 0 until a complete interval has been judged.
- R9: steer_up and steer_dn are never 1 together. Whenever lock=1, pd_en=1 as well. Steering never coexists with pd_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Local recovered-rate clock; all outputs are in this domain |
| ref_clk | input | 1 | Reference clock; may stop |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rate_sel | input | 1 | Line rate: 0 = lower rate (ratio RATE_LO_DIV), 1 = higher rate (RATE_HI_DIV) |
| ref_sel | input | 1 | Reference: 0 = higher frequency (REF_HI_DIV), 1 = lower frequency (REF_LO_DIV) |
| lock | output | 1 | Reference present and frequency inside the window |
| pd_en | output | 1 | Phase detector enable |
| steer_up | output | 1 | Raise oscillator frequency |
| steer_dn | output | 1 | Lower oscillator frequency |

## Verification
The hardest situation to reach is a reference that stops and later resumes partway through an interval. The stale partial interval must be discarded and must never produce a spurious steering command. The bench gates the reference clock off long enough for the watchdog to fire, checks that everything is cleared, and restarts the reference at an arbitrary phase. It then confirms that lock stays low shortly after the restart and returns only after a full interval. Mismatched rate and reference selections against a fixed reference period expose the divider ratios as counts of double or half the nominal value.

// File: rtl/fdet_pkg.sv
package fdet_pkg;
  typedef enum logic [1:0] {
    STEER_NONE = 2'd0,
    STEER_UP   = 2'd1,
    STEER_DN   = 2'd2
  } steer_e;

  function automatic int win_margin(input int cycles, input int ppm);
    longint prod;
    prod = longint'(cycles) * longint'(ppm);
    return int'(prod / 64'd1000000);
  endfunction
endpackage

// File: rtl/fdet_ref_timer.sv
module fdet_ref_timer #(
  parameter int IVL_REF_CYCLES = 4096
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic beat_tgl,
  output logic ivl_tgl
);
  localparam int CNT_W = (IVL_REF_CYCLES > 2) ? $clog2(IVL_REF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IVL_REF_CYCLES - 1);

  logic [1:0]       rst_sync;
  logic             rst_ref_n;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ref_n = rst_sync[1];

  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      cnt      <= '0;
      beat_tgl <= 1'b0;
      ivl_tgl  <= 1'b0;
    end else begin
      beat_tgl <= ~beat_tgl;
      if (cnt == LAST) begin
        cnt     <= '0;
        ivl_tgl <= ~ivl_tgl;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fdet_tgl_sync.sv
module fdet_tgl_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [2:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 3'b000;
    else        stage <= {stage[1:0], tgl_in};
  end

  assign pulse = stage[2] ^ stage[1];
endmodule

// File: rtl/fdet_divider.sv
module fdet_divider #(
  parameter int RATE_LO_DIV = 16,
  parameter int RATE_HI_DIV = 4,
  parameter int REF_HI_DIV  = 64,
  parameter int REF_LO_DIV  = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  input  logic ref_sel,
  output logic tick
);
  localparam int S1_MAX = (RATE_LO_DIV > RATE_HI_DIV) ? RATE_LO_DIV : RATE_HI_DIV;
  localparam int S2_MAX = (REF_LO_DIV > REF_HI_DIV) ? REF_LO_DIV : REF_HI_DIV;
  localparam int W1 = (S1_MAX > 2) ? $clog2(S1_MAX) : 1;
  localparam int W2 = (S2_MAX > 2) ? $clog2(S2_MAX) : 1;

  logic [W1-1:0] c1, last1;
  logic [W2-1:0] c2, last2;
  logic          t1;

  assign last1 = rate_sel ? W1'(RATE_HI_DIV - 1) : W1'(RATE_LO_DIV - 1);
  assign last2 = ref_sel  ? W2'(REF_LO_DIV - 1)  : W2'(REF_HI_DIV - 1);
  assign t1    = (c1 >= last1);
  assign tick  = t1 && (c2 >= last2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= '0;
      c2 <= '0;
    end else begin
      c1 <= t1 ? '0 : c1 + 1'b1;
      if (t1) c2 <= (c2 >= last2) ? '0 : c2 + 1'b1;
    end
  end
endmodule

// File: rtl/fdet_watchdog.sv
module fdet_watchdog #(
  parameter int WDOG_CYCLES = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  output logic expire,
  output logic ref_dead
);
  localparam int WW = $clog2(WDOG_CYCLES + 1);
  localparam logic [WW-1:0] LIMIT = WW'(WDOG_CYCLES);

  logic [WW-1:0] cnt;

  assign expire = !beat && !ref_dead && (cnt == LIMIT - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ref_dead <= 1'b0;
    end else if (beat) begin
      cnt      <= '0;
      ref_dead <= 1'b0;
    end else begin
      if (cnt != LIMIT) cnt <= cnt + 1'b1;
      if (expire)       ref_dead <= 1'b1;
    end
  end
endmodule

// File: rtl/fdet_judge.sv
module fdet_judge
  import fdet_pkg::*;
#(
  parameter int IVL_REF_CYCLES = 4096,
  parameter int TOL_PPM        = 1000,
  parameter int SPAN           = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   ivl_pulse,
  input  logic   wd_expire,
  input  logic   ref_dead,
  output logic   in_win,
  output steer_e steer
);
  localparam int MARGIN = win_margin(IVL_REF_CYCLES, TOL_PPM);
  localparam int LO_B   = IVL_REF_CYCLES - MARGIN;
  localparam int HI_B   = IVL_REF_CYCLES + MARGIN;
  localparam int CW     = $clog2(HI_B * SPAN + 1);
  localparam logic [CW-1:0] SAT  = {CW{1'b1}};
  localparam logic [CW:0]   LO_V = (CW+1)'(LO_B);
  localparam logic [CW:0]   HI_V = (CW+1)'(HI_B);

  logic [CW-1:0] meas;
  logic [CW:0]   snap;
  logic          skip;

  assign snap = {1'b0, meas} + (CW+1)'(tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas   <= '0;
      skip   <= 1'b1;
      in_win <= 1'b0;
      steer  <= STEER_NONE;
    end else if (wd_expire) begin
      meas   <= '0;
      skip   <= 1'b1;
      in_win <= 1'b0;
      steer  <= STEER_NONE;
    end else if (ref_dead) begin
      meas <= '0;
    end else if (ivl_pulse) begin
      meas <= '0;
      if (skip) begin
        skip <= 1'b0;
      end else if (snap > HI_V) begin
        in_win <= 1'b0;
        steer  <= STEER_DN;
      end else if (snap < LO_V) begin
        in_win <= 1'b0;
        steer  <= STEER_UP;
      end else begin
        in_win <= 1'b1;
        steer  <= STEER_NONE;
      end
    end else if (tick && meas != SAT) begin
      meas <= meas + 1'b1;
    end
  end
endmodule

// File: rtl/freq_window_det.sv
module freq_window_det
  import fdet_pkg::*;
#(
  parameter int IVL_REF_CYCLES = 4096,
  parameter int TOL_PPM        = 1000,
  parameter int RATE_LO_DIV    = 16,
  parameter int RATE_HI_DIV    = 4,
  parameter int REF_HI_DIV     = 64,
  parameter int REF_LO_DIV     = 128,
  parameter int WDOG_CYCLES    = 8192
) (
  input  logic vco_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic rate_sel,
  input  logic ref_sel,
  output logic lock,
  output logic pd_en,
  output logic steer_up,
  output logic steer_dn
);
  localparam int D_MAX = ((RATE_LO_DIV > RATE_HI_DIV) ? RATE_LO_DIV : RATE_HI_DIV) *
                         ((REF_LO_DIV > REF_HI_DIV) ? REF_LO_DIV : REF_HI_DIV);
  localparam int D_MIN = ((RATE_LO_DIV < RATE_HI_DIV) ? RATE_LO_DIV : RATE_HI_DIV) *
                         ((REF_LO_DIV < REF_HI_DIV) ? REF_LO_DIV : REF_HI_DIV);
  localparam int SPAN  = (D_MAX + D_MIN - 1) / D_MIN;

  logic [1:0] tgl_ref;
  logic [1:0] tgl_pulse;
  logic       beat_pulse, ivl_pulse;
  logic       tick, wd_expire, ref_dead, in_win;
  steer_e     steer;

  fdet_ref_timer #(.IVL_REF_CYCLES(IVL_REF_CYCLES)) u_timer (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .beat_tgl(tgl_ref[0]),
    .ivl_tgl (tgl_ref[1])
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_xing
      fdet_tgl_sync u_sync (
        .clk   (vco_clk),
        .rst_n (rst_n),
        .tgl_in(tgl_ref[g]),
        .pulse (tgl_pulse[g])
      );
    end
  endgenerate

  assign beat_pulse = tgl_pulse[0];
  assign ivl_pulse  = tgl_pulse[1];

  fdet_divider #(
    .RATE_LO_DIV(RATE_LO_DIV), .RATE_HI_DIV(RATE_HI_DIV),
    .REF_HI_DIV (REF_HI_DIV),  .REF_LO_DIV (REF_LO_DIV)
  ) u_div (
    .clk     (vco_clk),
    .rst_n   (rst_n),
    .rate_sel(rate_sel),
    .ref_sel (ref_sel),
    .tick    (tick)
  );

  fdet_watchdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wdog (
    .clk     (vco_clk),
    .rst_n   (rst_n),
    .beat    (beat_pulse),
    .expire  (wd_expire),
    .ref_dead(ref_dead)
  );

  fdet_judge #(
    .IVL_REF_CYCLES(IVL_REF_CYCLES), .TOL_PPM(TOL_PPM), .SPAN(SPAN)
  ) u_judge (
    .clk      (vco_clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ivl_pulse(ivl_pulse),
    .wd_expire(wd_expire),
    .ref_dead (ref_dead),
    .in_win   (in_win),
    .steer    (steer)
  );

  assign pd_en    = in_win;
  assign lock     = in_win && !ref_dead;
  assign steer_up = (steer == STEER_UP);
  assign steer_dn = (steer == STEER_DN);
endmodule

// File: rtl/fdet_checker.sv
module fdet_checker (
  input logic vco_clk,
  input logic rst_n,
  input logic lock,
  input logic pd_en,
  input logic steer_up,
  input logic steer_dn,
  input logic ivl_pulse,
  input logic wd_expire,
  input logic ref_dead
);
  AST_STEER_EXCLUSIVE: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !(steer_up && steer_dn)); // R9

  AST_LOCK_NEEDS_PD: assert property (@(posedge vco_clk) disable iff (!rst_n)
    lock |-> pd_en); // R9

  AST_STEER_BLOCKS_PD: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (steer_up || steer_dn) |-> !pd_en); // R4

  AST_HOLD_BETWEEN: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (!ivl_pulse && !wd_expire) |=> ($stable(pd_en) && $stable(steer_up) && $stable(steer_dn))); // R6

  AST_DEAD_CLEARS: assert property (@(posedge vco_clk) disable iff (!rst_n)
    wd_expire |=> (!pd_en && !steer_up && !steer_dn && !lock)); // R7

  AST_DEAD_NO_LOCK: assert property (@(posedge vco_clk) disable iff (!rst_n)
    ref_dead |-> !lock); // R7
endmodule

bind freq_window_det fdet_checker u_fdet_chk (
  .vco_clk  (vco_clk),
  .rst_n    (rst_n),
  .lock     (lock),
  .pd_en    (pd_en),
  .steer_up (steer_up),
  .steer_dn (steer_dn),
  .ivl_pulse(ivl_pulse),
  .wd_expire(wd_expire),
  .ref_dead (ref_dead)
);

// File: tb/freq_window_det_bench.sv
`timescale 1ns/1ps
module freq_window_det_bench;
  logic vco_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic rate_sel = 1'b1;
  logic ref_sel  = 1'b0;
  logic lock, pd_en, steer_up, steer_dn;

  realtime ref_half = 8.0;
  bit      ref_run  = 1'b1;

  typedef struct {
    logic  lk;
    logic  pd;
    logic  up;
    logic  dn;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // Bench ratios: rate_sel=0 -> 4, rate_sel=1 -> 2; ref_sel=0 -> 2, ref_sel=1 -> 4.
  // Window: 1000 +/- 1 ticks.
  freq_window_det #(
    .IVL_REF_CYCLES(1000), .TOL_PPM(1000),
    .RATE_LO_DIV(4), .RATE_HI_DIV(2),
    .REF_HI_DIV(2),  .REF_LO_DIV(4),
    .WDOG_CYCLES(64)
  ) u_freq_window_det (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .rate_sel(rate_sel), .ref_sel(ref_sel),
    .lock(lock), .pd_en(pd_en), .steer_up(steer_up), .steer_dn(steer_dn)
  );

  always #2 vco_clk = ~vco_clk;

  initial begin
    forever begin
      if (ref_run) begin
        #(ref_half);
        ref_clk = ~ref_clk;
      end else begin
        #1;
      end
    end
  end

  // Monitor: pop each expected item and compare at the next falling edge.
  initial begin
    forever begin
      wait (q.size() > 0);
      @(negedge vco_clk);
      begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (lock !== e.lk || pd_en !== e.pd || steer_up !== e.up || steer_dn !== e.dn) begin
          n_fail++;
          $display("FAIL %s: got lock=%b pd_en=%b up=%b dn=%b, expected lock=%b pd_en=%b up=%b dn=%b",
                   e.req, lock, pd_en, steer_up, steer_dn, e.lk, e.pd, e.up, e.dn);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge vco_clk);
  endtask

  task automatic expect_out(input logic lk, input logic pd, input logic up,
                            input logic dn, input string req);
    exp_t e;
    e.lk = lk; e.pd = pd; e.up = up; e.dn = dn; e.req = req;
    q.push_back(e);
    wait (q.size() == 0);
    @(posedge vco_clk);
  endtask

  initial begin
    wait_cyc(5);
    expect_out(0, 0, 0, 0, "R1 reset state");
    rst_n = 1'b1;

    // D = 2*2 = 4, ref 16 ns = 4 vco cycles: nominal, count 1000
    wait_cyc(10000);
    expect_out(1, 1, 0, 0, "R3 nominal ratio locks (R8 first interval skipped)");

    ref_half = 8.08;   // count 1010, above bound
    wait_cyc(10500);
    expect_out(0, 0, 0, 1, "R4 oscillator fast by 1%");

    ref_half = 7.92;   // count 990, below bound
    wait_cyc(10500);
    expect_out(0, 0, 1, 0, "R5 oscillator slow by 1%");

    ref_half = 8.024;  // count 1003, just beyond the window
    wait_cyc(10500);
    expect_out(0, 0, 0, 1, "R4 oscillator fast by 0.3%");

    ref_half = 8.0;
    wait_cyc(10500);
    expect_out(1, 1, 0, 0, "R3 back to nominal relocks");

    ref_run = 1'b0;    // reference stops
    wait_cyc(150);
    expect_out(0, 0, 0, 0, "R7 lost reference clears outputs");
    wait_cyc(2000);
    expect_out(0, 0, 0, 0, "R6 outputs hold while reference absent");

    ref_run = 1'b1;
    wait_cyc(60);
    expect_out(0, 0, 0, 0, "R8 no lock right after reference returns");
    wait_cyc(12000);
    expect_out(1, 1, 0, 0, "R8 lock after a full judged interval");

    // Reference 32 ns = 8 vco cycles, interval 8000 vco cycles
    ref_half = 16.0;
    rate_sel = 1'b1; ref_sel = 1'b1;   // 2*4 = 8
    wait_cyc(20500);
    expect_out(1, 1, 0, 0, "R2 rate hi with ref lo gives ratio 8");

    rate_sel = 1'b0; ref_sel = 1'b0;   // 4*2 = 8
    wait_cyc(20500);
    expect_out(1, 1, 0, 0, "R2 rate lo with ref hi gives ratio 8");

    rate_sel = 1'b1; ref_sel = 1'b0;   // 2*2 = 4 -> count 2000
    wait_cyc(20500);
    expect_out(0, 0, 0, 1, "R2 ratio 4 against ratio-8 reference steers down");

    rate_sel = 1'b0; ref_sel = 1'b1;   // 4*4 = 16 -> count 500
    wait_cyc(20500);
    expect_out(0, 0, 1, 0, "R2 ratio 16 against ratio-8 reference steers up");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge vco_clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule